// File: doc/BRIEF.md
# Buffer Descriptor Ring Walker

This block sequences one DMA channel through a ring of buffer descriptors kept in a small local descriptor memory. Each descriptor is three 32-bit words. The first word holds a byte count, a status byte and a command byte. The second word holds the buffer address and the third holds an extended address. Ownership, wrap, continue, interrupt and error markers all live in the status byte of each descriptor. The same hardware can therefore run a one-shot scatter list, which ends on a descriptor without the continue marker, or a cyclic ring. In a cyclic ring the last descriptor points back to the base, and the walk stops once it reaches a descriptor that has already been handed back.

A pulse on `start` latches a base index and clears the running byte total. The walker then fetches the current descriptor and checks that the engine owns it. It decodes the access width from the command and screens the count and address for alignment. Next it asks an external data mover for the transfer through a request/done handshake that carries an error flag. When the transfer ends, the walker writes the status back with ownership returned to the host and the error marker set or cleared. It then advances to the next index, returns to the base, or stops. A host-side memory port loads descriptors and reads back the written status while the channel is idle.

Top module: `bd_ring_walker`

## Requirements
- R1: Descriptor word 0 holds the count in bits 15:0, the status in bits 23:16 and the command in bits 31:24. Word 1 is the buffer address and word 2 is the extended address. The host port selects a word with `hst_word` (0, 1 or 2) at index `hst_idx`, and read data appears one clock after the read is issued.
- R2: A `start` pulse while idle loads `cur_idx` with `base_idx`, clears `byte_total` to 0 and begins walking at that index.
- R3: Status bit 0 set means the engine owns the descriptor. If it is clear, the walker goes idle (`busy` low) without a request and without changing the descriptor, and `cur_idx` stays on that descriptor.
- R4: A transfer request presents word 1 on `xfer_addr`, word 2 on `xfer_ext` and the count on `xfer_count`. `xfer_width` encodes 8/16/32-bit access as 0/1/2. Command 0 selects 32-bit, command 2 selects 16-bit and command 1 selects 8-bit. The request stays high with stable fields until `xfer_done`.
- R5: With 32-bit access, a count or address whose two low bits are not zero is a fault. With 16-bit access, an odd count or address is a fault. Any command other than 0, 1 or 2 is also a fault. A fault marks the descriptor in error, issues no request and stops the channel.
- R6: After each owned descriptor, word 0 is rewritten with status bit 0 cleared and status bit 4 holding that descriptor's error outcome. The count, the command and the other status bits are kept.
- R7: `xfer_err` sampled with `xfer_done` sets the error bit of that descriptor, stops the channel with `cur_idx` on it, and adds nothing to `byte_total`.
- R8: When status bit 2 (continue) is clear, the channel stops after that descriptor completes and `cur_idx` stays on it.
- R9: When status bit 2 is set, status bit 1 (wrap) sends the walk back to the base index. Otherwise the walk moves to the next index modulo the ring size (16 by default).
- R10: Each completed descriptor with status bit 3 (interrupt) set produces a one-cycle pulse on `irq`. This includes descriptors that complete in error.
- R11: `byte_total` accumulates the count of every successful transfer, up to 0xFFFF bytes per descriptor.
- R12: After reset, `busy`, `irq` and `xfer_req` are low and `cur_idx` and `byte_total` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk at `base_idx` (ignored while busy) |
| base_idx | input | IDX_W | Base descriptor index of the ring |
| hst_en | input | 1 | Host memory port access enable |
| hst_we | input | 1 | Host write (with `hst_en`) |
| hst_idx | input | IDX_W | Host descriptor index |
| hst_word | input | 2 | Host word select within the descriptor |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, one cycle after the read |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_addr | output | 32 | Buffer address |
| xfer_ext | output | 32 | Extended address |
| xfer_count | output | 16 | Byte count |
| xfer_width | output | 2 | Access width: 0=8, 1=16, 2=32 bit |
| xfer_done | input | 1 | Data mover completion strobe |
| xfer_err | input | 1 | Transfer failure, valid with `xfer_done` |
| busy | output | 1 | Channel is walking |
| irq | output | 1 | One-cycle descriptor-complete interrupt |
| cur_idx | output | IDX_W | Current descriptor index |
| byte_total | output | TOTAL_W | Bytes moved since the last start |

## Verification
The bench targets five cases. A cyclic ring must stop at the base once every descriptor has been handed back; a walker that ignored ownership would loop forever or reuse stale descriptors. A non-wrapping descriptor at the top index must roll over to index 0, where a mis-sized increment would stray outside the ring. Misaligned 16- and 32-bit descriptors and an unknown command must yield an error write-back with no request; a design that skipped the screen would show a request that the reference model does not expect. An injected mover failure must set the error bit, stop the channel and leave the total unchanged, and a design that accumulated regardless would report a total that is too large.

// File: rtl/bdw_pkg.sv
`timescale 1ns/1ps
package bdw_pkg;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 16;
  // status byte bit positions
  localparam int ST_OWN  = 0;
  localparam int ST_WRAP = 1;
  localparam int ST_CONT = 2;
  localparam int ST_INTR = 3;
  localparam int ST_ERR  = 4;
  localparam int ST_EXT  = 7;
  // status byte and command byte placement in word 0
  localparam int STAT_LSB = 16;
  localparam int CMD_LSB  = 24;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2
  } width_e;

  typedef enum logic [2:0] {
    S_IDLE, S_F0, S_F1, S_F2, S_F3, S_CHECK, S_XFER, S_WB
  } walk_state_e;
endpackage

// File: rtl/bdw_desc_ram.sv
`timescale 1ns/1ps
module bdw_desc_ram #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                a_en,
  input  logic                a_we,
  input  logic [IDX_W+1:0]    a_addr,
  input  logic [DATA_W-1:0]   a_wdata,
  output logic [DATA_W-1:0]   a_rdata,
  input  logic                b_en,
  input  logic                b_we,
  input  logic [IDX_W+1:0]    b_addr,
  input  logic [DATA_W-1:0]   b_wdata,
  output logic [DATA_W-1:0]   b_rdata
);
  localparam int DEPTH = (1 << IDX_W) * 4;

  logic [DATA_W-1:0] mem [DEPTH];

  // two ports, walker write listed last so it wins a same-address collision
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_wdata;
      b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/bdw_cmd_decode.sv
`timescale 1ns/1ps
module bdw_cmd_decode
  import bdw_pkg::*;
(
  input  logic [7:0]        cmd,
  input  logic [CNT_W-1:0]  count,
  input  logic [WORD_W-1:0] addr,
  output width_e            width,
  output logic              fault
);
  always_comb begin
    width = WID_8;
    fault = 1'b0;
    case (cmd)
      8'd0: begin
        width = WID_32;
        fault = (|count[1:0]) | (|addr[1:0]);
      end
      8'd2: begin
        width = WID_16;
        fault = count[0] | addr[0];
      end
      8'd1: begin
        width = WID_8;
        fault = 1'b0;
      end
      default: begin
        width = WID_8;
        fault = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/bdw_walker_fsm.sv
`timescale 1ns/1ps
module bdw_walker_fsm
  import bdw_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int TOTAL_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [IDX_W-1:0]    base_idx,
  output logic                m_en,
  output logic                m_we,
  output logic [IDX_W+1:0]    m_addr,
  output logic [WORD_W-1:0]   m_wdata,
  input  logic [WORD_W-1:0]   m_rdata,
  output logic [7:0]          dec_cmd,
  output logic [CNT_W-1:0]    dec_count,
  output logic [WORD_W-1:0]   dec_addr,
  input  width_e              dec_width,
  input  logic                dec_fault,
  output logic                xfer_req,
  output logic [WORD_W-1:0]   xfer_addr,
  output logic [WORD_W-1:0]   xfer_ext,
  output logic [CNT_W-1:0]    xfer_count,
  output logic [1:0]          xfer_width,
  input  logic                xfer_done,
  input  logic                xfer_err,
  output logic                busy,
  output logic                irq,
  output logic [IDX_W-1:0]    cur_idx,
  output logic [TOTAL_W-1:0]  byte_total
);
  walk_state_e       state;
  logic [IDX_W-1:0]  idx_q, base_q;
  logic [WORD_W-1:0] w0_q, w1_q, w2_q;
  logic              fail_q, req_q, irq_q;
  width_e            width_q;
  logic [TOTAL_W-1:0] total_q;
  logic [7:0]        stat;

  assign stat = w0_q[STAT_LSB +: 8];

  // descriptor fields presented to the decoder
  assign dec_cmd   = w0_q[CMD_LSB +: 8];
  assign dec_count = w0_q[CNT_W-1:0];
  assign dec_addr  = w1_q;

  // descriptor memory port
  always_comb begin
    m_en    = 1'b0;
    m_we    = 1'b0;
    m_addr  = {idx_q, 2'd0};
    m_wdata = w0_q;
    case (state)
      S_F0: begin m_en = 1'b1; m_addr = {idx_q, 2'd0}; end
      S_F1: begin m_en = 1'b1; m_addr = {idx_q, 2'd1}; end
      S_F2: begin m_en = 1'b1; m_addr = {idx_q, 2'd2}; end
      S_WB: begin
        m_en    = 1'b1;
        m_we    = 1'b1;
        m_addr  = {idx_q, 2'd0};
        m_wdata = w0_q;
        m_wdata[STAT_LSB + ST_OWN] = 1'b0;
        m_wdata[STAT_LSB + ST_ERR] = fail_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
      fail_q  <= 1'b0;
      req_q   <= 1'b0;
      irq_q   <= 1'b0;
      width_q <= WID_8;
      total_q <= '0;
    end else begin
      irq_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          idx_q   <= base_idx;
          base_q  <= base_idx;
          total_q <= '0;
          fail_q  <= 1'b0;
          state   <= S_F0;
        end
        S_F0: state <= S_F1;
        S_F1: begin w0_q <= m_rdata; state <= S_F2; end
        S_F2: begin w1_q <= m_rdata; state <= S_F3; end
        S_F3: begin w2_q <= m_rdata; state <= S_CHECK; end
        S_CHECK: begin
          if (!stat[ST_OWN]) begin
            state <= S_IDLE;
          end else if (dec_fault) begin
            fail_q <= 1'b1;
            state  <= S_WB;
          end else begin
            fail_q  <= 1'b0;
            width_q <= dec_width;
            req_q   <= 1'b1;
            state   <= S_XFER;
          end
        end
        S_XFER: if (xfer_done) begin
          req_q  <= 1'b0;
          fail_q <= xfer_err;
          state  <= S_WB;
        end
        S_WB: begin
          irq_q <= stat[ST_INTR];
          if (!fail_q) total_q <= total_q + TOTAL_W'(w0_q[CNT_W-1:0]);
          if (fail_q || !stat[ST_CONT]) begin
            state <= S_IDLE;
          end else begin
            idx_q <= stat[ST_WRAP] ? base_q : idx_q + 1'b1;
            state <= S_F0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign xfer_req   = req_q;
  assign xfer_addr  = w1_q;
  assign xfer_ext   = w2_q;
  assign xfer_count = w0_q[CNT_W-1:0];
  assign xfer_width = width_q;
  assign busy       = (state != S_IDLE);
  assign irq        = irq_q;
  assign cur_idx    = idx_q;
  assign byte_total = total_q;

  // R2: a start while idle sets the index to the base and clears the total
  a_r2_start_init: assert property (@(posedge clk) disable iff (rst)
    (start && state == S_IDLE) |=> (byte_total == '0 && cur_idx == $past(base_idx)));

  // R4: request fields are held until the mover answers
  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_count)
                                 && $stable(xfer_width)));

  // R5: no 32-bit request ever leaves with a misaligned count or address
  a_r5_aligned_word: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && xfer_width == WID_32) |-> (xfer_count[1:0] == 2'd0 && xfer_addr[1:0] == 2'd0));

  // R3: a descriptor not owned ends the walk with no request
  a_r3_unowned_stop: assert property (@(posedge clk) disable iff (rst)
    (state == S_CHECK && !stat[ST_OWN]) |=> (!busy && !xfer_req));

  // R10: interrupt is a single-cycle pulse
  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R7: a failed descriptor adds nothing to the total
  a_r7_no_count_on_fail: assert property (@(posedge clk) disable iff (rst)
    (state == S_WB && fail_q) |=> $stable(byte_total));
endmodule

// File: rtl/bd_ring_walker.sv
`timescale 1ns/1ps
module bd_ring_walker
  import bdw_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int TOTAL_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [IDX_W-1:0]    base_idx,
  input  logic                hst_en,
  input  logic                hst_we,
  input  logic [IDX_W-1:0]    hst_idx,
  input  logic [1:0]          hst_word,
  input  logic [31:0]         hst_wdata,
  output logic [31:0]         hst_rdata,
  output logic                xfer_req,
  output logic [31:0]         xfer_addr,
  output logic [31:0]         xfer_ext,
  output logic [15:0]         xfer_count,
  output logic [1:0]          xfer_width,
  input  logic                xfer_done,
  input  logic                xfer_err,
  output logic                busy,
  output logic                irq,
  output logic [IDX_W-1:0]    cur_idx,
  output logic [TOTAL_W-1:0]  byte_total
);
  logic              m_en, m_we;
  logic [IDX_W+1:0]  m_addr;
  logic [WORD_W-1:0] m_wdata, m_rdata;
  logic [7:0]        dec_cmd;
  logic [CNT_W-1:0]  dec_count;
  logic [WORD_W-1:0] dec_addr;
  width_e            dec_width;
  logic              dec_fault;

  bdw_desc_ram #(.IDX_W(IDX_W), .DATA_W(WORD_W)) ram_i (
    .clk     (clk),
    .a_en    (hst_en),
    .a_we    (hst_we),
    .a_addr  ({hst_idx, hst_word}),
    .a_wdata (hst_wdata),
    .a_rdata (hst_rdata),
    .b_en    (m_en),
    .b_we    (m_we),
    .b_addr  (m_addr),
    .b_wdata (m_wdata),
    .b_rdata (m_rdata)
  );

  bdw_cmd_decode dec_i (
    .cmd   (dec_cmd),
    .count (dec_count),
    .addr  (dec_addr),
    .width (dec_width),
    .fault (dec_fault)
  );

  bdw_walker_fsm #(.IDX_W(IDX_W), .TOTAL_W(TOTAL_W)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .base_idx   (base_idx),
    .m_en       (m_en),
    .m_we       (m_we),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata),
    .m_rdata    (m_rdata),
    .dec_cmd    (dec_cmd),
    .dec_count  (dec_count),
    .dec_addr   (dec_addr),
    .dec_width  (dec_width),
    .dec_fault  (dec_fault),
    .xfer_req   (xfer_req),
    .xfer_addr  (xfer_addr),
    .xfer_ext   (xfer_ext),
    .xfer_count (xfer_count),
    .xfer_width (xfer_width),
    .xfer_done  (xfer_done),
    .xfer_err   (xfer_err),
    .busy       (busy),
    .irq        (irq),
    .cur_idx    (cur_idx),
    .byte_total (byte_total)
  );
endmodule

// File: tb/bd_ring_walker_tb_top.sv
`timescale 1ns/1ps
module bd_ring_walker_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  base_idx = '0;
  logic        hst_en = 1'b0, hst_we = 1'b0;
  logic [3:0]  hst_idx = '0;
  logic [1:0]  hst_word = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        xfer_req;
  logic [31:0] xfer_addr, xfer_ext;
  logic [15:0] xfer_count;
  logic [1:0]  xfer_width;
  logic        xfer_done = 1'b0, xfer_err = 1'b0;
  logic        busy, irq;
  logic [3:0]  cur_idx;
  logic [31:0] byte_total;

  always #2 clk = ~clk;

  bd_ring_walker dut_i (
    .clk(clk), .rst(rst), .start(start), .base_idx(base_idx),
    .hst_en(hst_en), .hst_we(hst_we), .hst_idx(hst_idx), .hst_word(hst_word),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_ext(xfer_ext),
    .xfer_count(xfer_count), .xfer_width(xfer_width),
    .xfer_done(xfer_done), .xfer_err(xfer_err),
    .busy(busy), .irq(irq), .cur_idx(cur_idx), .byte_total(byte_total)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench mirror of descriptor memory and reference outcomes
  logic [31:0] m0 [N];
  logic [31:0] m1 [N];
  logic [31:0] m2 [N];
  bit          err_plan [64];
  int          model_no = 0;
  int          mv_no = 0;
  int          wait_cnt = 0;
  bit          seen = 0;
  int          irq_seen = 0;
  logic [31:0] qa [$];
  logic [31:0] qe [$];
  logic [15:0] qc [$];
  logic [1:0]  qw [$];
  int          exp_idx, exp_irq;
  longint      exp_total;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // data mover model, request comparison and interrupt counter
  always @(negedge clk) begin
    if (irq) irq_seen++;
    if (xfer_done) begin
      xfer_done = 1'b0;
      xfer_err  = 1'b0;
    end else if (xfer_req) begin
      if (!seen) begin
        seen = 1;
        checks++;
        if (qa.size() == 0) begin
          errors++;
          $display("FAIL R4/R5 unexpected request actual addr=%0h count=%0h expected none",
                   xfer_addr, xfer_count);
        end else if (xfer_addr !== qa[0] || xfer_ext !== qe[0] ||
                     xfer_count !== qc[0] || xfer_width !== qw[0]) begin
          errors++;
          $display("FAIL R4 request actual %h %h %h %0d expected %h %h %h %0d",
                   xfer_addr, xfer_ext, xfer_count, xfer_width, qa[0], qe[0], qc[0], qw[0]);
        end
      end
      if (wait_cnt >= mv_no % 3) begin
        xfer_done = 1'b1;
        xfer_err  = err_plan[mv_no];
        mv_no++;
        wait_cnt = 0;
        seen = 0;
        if (qa.size() != 0) begin
          void'(qa.pop_front()); void'(qe.pop_front());
          void'(qc.pop_front()); void'(qw.pop_front());
        end
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic hwrite(input int i, input int w, input logic [31:0] d);
    @(negedge clk);
    hst_en = 1; hst_we = 1; hst_idx = 4'(i); hst_word = 2'(w); hst_wdata = d;
    @(negedge clk);
    hst_en = 0; hst_we = 0;
  endtask

  task automatic hread(input int i, input int w, output logic [31:0] d);
    @(negedge clk);
    hst_en = 1; hst_we = 0; hst_idx = 4'(i); hst_word = 2'(w);
    @(negedge clk);
    hst_en = 0;
    d = hst_rdata;
  endtask

  task automatic put_desc(input int i, input logic [7:0] cmd, input logic [7:0] st,
                          input logic [15:0] cnt, input logic [31:0] a, input logic [31:0] e);
    m0[i] = {cmd, st, cnt}; m1[i] = a; m2[i] = e;
    hwrite(i, 0, m0[i]);
    hwrite(i, 1, a);
    hwrite(i, 2, e);
  endtask

  // reference walk over the mirror
  task automatic model_walk(input int base);
    int idx = base;
    exp_total = 0; exp_irq = 0; exp_idx = base;
    for (int step = 0; step < 64; step++) begin
      logic [7:0] s, cmd;
      logic [15:0] cnt;
      bit bad, fail;
      logic [1:0] wid;
      s = m0[idx][23:16]; cmd = m0[idx][31:24]; cnt = m0[idx][15:0];
      exp_idx = idx;
      if (!s[0]) break;
      wid = 2'd0;
      if (cmd == 8'd0) begin bad = (cnt % 4 != 0) || (m1[idx] % 4 != 0); wid = 2'd2; end
      else if (cmd == 8'd2) begin bad = (cnt % 2 != 0) || (m1[idx] % 2 != 0); wid = 2'd1; end
      else if (cmd == 8'd1) bad = 0;
      else bad = 1;
      fail = bad;
      if (!bad) begin
        qa.push_back(m1[idx]); qe.push_back(m2[idx]); qc.push_back(cnt); qw.push_back(wid);
        fail = err_plan[model_no];
        model_no++;
      end
      s[0] = 1'b0; s[4] = fail;
      m0[idx][23:16] = s;
      if (s[3]) exp_irq++;
      if (!fail) exp_total += cnt;
      if (fail || !s[2]) break;
      idx = s[1] ? base : (idx + 1) % N;
    end
  endtask

  task automatic run_case(input int base, input string tag);
    logic [31:0] d;
    bit ok = 1;
    model_walk(base);
    irq_seen = 0;
    @(negedge clk);
    base_idx = 4'(base); start = 1;
    @(negedge clk);
    start = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(byte_total == 32'(exp_total), {tag, " R11 byte_total"}, byte_total, exp_total);
    chk(cur_idx == 4'(exp_idx), {tag, " R8/R9 cur_idx"}, cur_idx, exp_idx);
    chk(irq_seen == exp_irq, {tag, " R10 irq count"}, irq_seen, exp_irq);
    chk(qa.size() == 0, {tag, " R4 missing requests"}, qa.size(), 0);
    for (int i = 0; i < N; i++) begin
      hread(i, 0, d);
      if (d !== m0[i]) begin
        ok = 0;
        $display("FAIL %s R6 word0[%0d] actual=%h expected=%h", tag, i, d, m0[i]);
      end
    end
    checks++;
    if (!ok) errors++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 64; i++) err_plan[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !irq && !xfer_req, "R12 reset controls", {busy, irq, xfer_req}, 0);
    chk(cur_idx == 0 && byte_total == 0, "R12 reset idx/total", byte_total, 0);

    for (int i = 0; i < N; i++) put_desc(i, 8'h00, 8'h00, 16'h0, 32'h0, 32'h0);

    // R1 layout and host port readback
    put_desc(2, 8'h00, 8'h05, 16'd64, 32'h0000_1000, 32'hE000_0002);
    hread(2, 1, d); chk(d == 32'h0000_1000, "R1 word1 readback", d, 32'h1000);
    hread(2, 2, d); chk(d == 32'hE000_0002, "R1 word2 readback", d, 32'hE0000002);
    hread(2, 0, d); chk(d == 32'h0005_0040, "R1 word0 packing", d, 32'h00050040);

    // one-shot list, three widths: R2 R4 R6 R8 R10 R11
    put_desc(3, 8'h02, 8'h05, 16'd6, 32'h0000_2002, 32'hE000_0003);
    put_desc(4, 8'h01, 8'h89, 16'd5, 32'h0000_3001, 32'hE000_0004);
    run_case(2, "scatter R2 R8");

    // cyclic ring with wrap, stops when base handed back: R9 R10
    for (int i = 8; i < 12; i++)
      put_desc(i, 8'h00, (i == 11) ? 8'h0F : 8'h0D, 16'd16, 32'h100 * i, 32'(i));
    run_case(8, "cyclic R9");

    // unowned base: no request, total restarts at zero: R3 R2
    run_case(5, "unowned R3 R2");

    // 32-bit misaligned count: R5
    put_desc(0, 8'h00, 8'h05, 16'd8, 32'h0000_4000, 32'h0);
    put_desc(1, 8'h00, 8'h0D, 16'd6, 32'h0000_4100, 32'h0);
    run_case(0, "align32 R5");

    // 16-bit odd address: R5
    put_desc(6, 8'h02, 8'h05, 16'd4, 32'h0000_5001, 32'h0);
    run_case(6, "align16 R5");

    // unknown command: R5
    put_desc(7, 8'h03, 8'h0D, 16'd4, 32'h0000_6000, 32'h0);
    run_case(7, "badcmd R5");

    // mover failure on second transfer: R7
    err_plan[model_no + 1] = 1;
    put_desc(12, 8'h01, 8'h05, 16'd3, 32'h0000_7000, 32'h1);
    put_desc(13, 8'h01, 8'h0D, 16'd7, 32'h0000_7100, 32'h2);
    put_desc(14, 8'h01, 8'h05, 16'd9, 32'h0000_7200, 32'h3);
    run_case(12, "xfererr R7");

    // top index rolls to zero, max count: R9 R11
    put_desc(15, 8'h01, 8'h05, 16'hFFFF, 32'h0000_8000, 32'h0);
    put_desc(0, 8'h01, 8'h01, 16'd1, 32'h0000_9000, 32'h0);
    run_case(15, "rollover R9 R11");

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule